// File: doc/BRIEF.md
# Unipolar Stepper Phase Sequencer

This block drives the four winding outputs of a four-phase unipolar stepper motor. It walks a full-step pattern in which two neighbouring windings are always energized. The patterns are 4'b1100, 4'b0110, 4'b0011 and 4'b1001, and the walk wraps around endlessly.

A down-counter spaces the steps. When it reaches zero the pattern advances by one position and the counter reloads from the `interval` input. While the counter runs, the output stays constant. A direction input selects the walk order. Dropping `enable` freezes both the pattern and the counter, so motion resumes where it stopped. Each pattern change comes with a one-cycle `step_pulse`.

Top module: `step_phaser`

## Requirements
- R1: While reset (`rst_n` low) is applied and just after it, `phases` is 4'b1100, `step_pulse` is 0 and the internal step counter is zero.
- R2: With `reverse` low, each step advances `phases` in the order 1100 -> 0110 -> 0011 -> 1001.
- R3: With `reverse` high, each step moves `phases` in the order 1100 -> 1001 -> 0011 -> 0110.
- R4: After the fourth pattern in either direction, the walk wraps back to the first and continues without end.
- R5: While `enable` is high, a step occurs on a clock edge where the counter is zero, and the counter then reloads from `interval`. On every other enabled edge the counter decrements. Steps are therefore `interval`+1 cycles apart, and `phases` is constant in between.
- R6: `step_pulse` is high for exactly the one cycle that follows each edge where `phases` changed, and it is low at all other times.
- R7: While `enable` is low, `phases` and the step counter hold their values and `step_pulse` stays low. After `enable` returns, the next step comes once the remaining count has run out.
- R8: With `interval` = 0, a step occurs on every enabled clock edge.
- R9: `phases` is always one of the four patterns, so exactly two adjacent windings (wrapping bit 3 to bit 0) are on.
- R10: A change of `reverse` takes effect at the next step and continues from the current pattern, without resetting the walk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the sequencer; low holds the phase and the counter |
| reverse | input | 1 | Walk order: 0 forward, 1 backward |
| interval | input | IVL_W | Count reloaded after each step; gap is interval+1 cycles |
| phases | output | 4 | Winding drive vector |
| step_pulse | output | 1 | One-cycle strobe following each pattern change |

## Verification
Several properties are checked on every cycle. The pattern must stay legal, and the strobe must line up with a pattern change. A frozen state under a low enable is checked too. Each step must take the rotation that `reverse` picks, and the counter must reload from `interval` after a step. Only the directed scenarios can show the full walk and its wrap, the exact spacing in cycles for a given interval, and the every-cycle stepping at interval zero. They also show that the remaining count survives a pause, and that a mid-run direction flip continues from the pattern currently driven.

// File: rtl/step_phaser.sv
module step_phaser #(
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             reverse,
  input  logic [IVL_W-1:0] interval,
  output logic [3:0]       phases,
  output logic             step_pulse
);

  logic [1:0]       slot_q;
  logic [IVL_W-1:0] wait_q;
  logic             fire;

  assign fire = enable && (wait_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q     <= 2'd0;
      wait_q     <= '0;
      step_pulse <= 1'b0;
    end else begin
      step_pulse <= fire;
      if (fire) begin
        slot_q <= reverse ? slot_q - 2'd1 : slot_q + 2'd1;
        wait_q <= interval;
      end else if (enable) begin
        wait_q <= wait_q - 1'b1;
      end
    end
  end

  always_comb begin
    case (slot_q)
      2'd0:    phases = 4'b1100;
      2'd1:    phases = 4'b0110;
      2'd2:    phases = 4'b0011;
      default: phases = 4'b1001;
    endcase
  end

endmodule

module step_phaser_checker #(
  parameter int IVL_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             reverse,
  input logic [IVL_W-1:0] interval,
  input logic [3:0]       phases,
  input logic             step_pulse,
  input logic [IVL_W-1:0] wait_q
);

  p_legal_pattern_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phases == 4'b1100) || (phases == 4'b0110) || (phases == 4'b0011) || (phases == 4'b1001));

  p_pulse_marks_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |-> (phases != $past(phases)));

  p_quiet_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !step_pulse |-> $stable(phases));

  p_disabled_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ($stable(phases) && $stable(wait_q) && !step_pulse));

  p_fwd_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !reverse && wait_q == '0) |=>
      (phases == {$past(phases[0]), $past(phases[3:1])}));

  p_rev_rotate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && reverse && wait_q == '0) |=>
      (phases == {$past(phases[2:0]), $past(phases[3])}));

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && wait_q == '0) |=> (wait_q == $past(interval)));

  p_countdown_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && wait_q != '0) |=> (wait_q == $past(wait_q) - 1'b1));

endmodule

bind step_phaser step_phaser_checker #(.IVL_W(IVL_W)) u_step_phaser_checker (
  .clk(clk), .rst_n(rst_n), .enable(enable), .reverse(reverse),
  .interval(interval), .phases(phases), .step_pulse(step_pulse), .wait_q(wait_q)
);

// File: tb/test_step_phaser.sv
module test_step_phaser;
  localparam int IVL_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enable = 1'b0;
  logic             reverse = 1'b0;
  logic [IVL_W-1:0] interval = '0;
  logic [3:0]       phases;
  logic             step_pulse;

  int checks = 0;
  int fails  = 0;
  int exp_idx = 0;

  always #4 clk = ~clk;

  step_phaser #(.IVL_W(IVL_W)) i_step_phaser (
    .clk(clk), .rst_n(rst_n), .enable(enable), .reverse(reverse),
    .interval(interval), .phases(phases), .step_pulse(step_pulse)
  );

  function automatic logic [3:0] pat(input int i);
    case (i & 3)
      0: return 4'b1100;
      1: return 4'b0110;
      2: return 4'b0011;
      default: return 4'b1001;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_steps(input int n, input int gap, input bit check_first, input string req);
    for (int k = 0; k < n; k++) begin
      int c = 0;
      do begin
        @(negedge clk);
        c++;
        if (!step_pulse) check({req, " hold between steps"}, phases, pat(exp_idx));
      end while (!step_pulse && c < 1000);
      exp_idx = reverse ? exp_idx - 1 : exp_idx + 1;
      check({req, " pattern"}, phases, pat(exp_idx));
      if (k > 0 || check_first) check({req, " R5 gap"}, c, gap);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 phases in reset", phases, 4'b1100);
    check("R1 pulse in reset", step_pulse, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 phases after reset", phases, 4'b1100);
    check("R1 pulse after reset", step_pulse, 0);
  endtask

  task automatic t_forward;
    interval = 16'd3;
    enable = 1'b1;
    run_steps(1, 1, 1'b1, "R2 first step");
    run_steps(6, 4, 1'b1, "R2 R4 R9 forward");
  endtask

  task automatic t_reverse;
    reverse = 1'b1;
    run_steps(6, 4, 1'b1, "R3 R4 R10 reverse");
  endtask

  task automatic t_hold;
    enable = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R7 held phases", phases, pat(exp_idx));
      check("R7 no pulse", step_pulse, 0);
    end
    enable = 1'b1;
    run_steps(1, 4, 1'b1, "R7 resume count");
  endtask

  task automatic t_zero;
    interval = '0;
    run_steps(1, 4, 1'b1, "R8 reload old");
    reverse = 1'b0;
    run_steps(8, 1, 1'b1, "R8 every cycle");
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_forward();
    t_reverse();
    t_hold();
    t_zero();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule